// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block sequences I2C master transactions one byte at a time. It sits between a register interface and a bit-level bus engine. Software loads one or two address header bytes, a transmit count, a receive count and transmit data. It then writes a command code. The command starts one of three transfers: a transfer that leaves the bus held without a STOP, a transfer closed by a STOP, or a combined write, repeated-start and read transfer done entirely in hardware.

The sequencer hands each bus action to the bit engine through a request/done handshake. The actions are START, STOP, byte write and byte read. Received bytes go into a receive FIFO. Outcomes are reported through a status word that holds sticky event bits and two live service flags. The receive count is read live throughout a read. Software can therefore lengthen or shorten a read after a length byte arrives.

Top module: `i2cseq_top`

## Requirements
- R1: A command write with bit 3 set while idle and with valid parameters starts a transfer. Bit 3 of `cmd_status` then reads 1 until the transfer ends, and `cmd_status[2:0]` holds the mode. A command write while busy is ignored.
- R2: Each bus action is held on `be_req` with stable `be_op` and `be_wdata` until `be_done`. Actions complete strictly in order, one per `be_done`. Operation codes: 0 START, 1 STOP, 2 byte write, 3 byte read.
- R3: Mode 1 (stop-terminated) issues START, header byte 1, header byte 2 only when header byte 1 bits [7:3] are 11110, then the data bytes, then STOP. It then sets status bit 10 (auto done) and bit 9 (stop complete).
- R4: Mode 0 (held) issues the same actions without the STOP. It sets status bit 11 only and leaves bits 9 and 10 clear.
- R5: Mode 2 (combined) issues START, header 1, the optional header 2, the transmit bytes, START, header 1 with bit 0 forced to 1, the receive bytes, then STOP. It then sets bits 10 and 9.
- R6: In modes 0 and 1 the direction comes from header 1 bit 0, where 1 means read. A read issues one byte-read action per byte, flags the final one with `be_last`, and pushes the bytes into the receive FIFO in order.
- R7: A rewrite of `rx_count` during a read changes the number of bytes read and which byte is flagged last.
- R8: A NAK on a header byte sets bit 4 and a NAK on a data byte sets bit 5. The NAK bit is set before the STOP is issued. Busy then stays set until that STOP completes, and bits 9, 10 and 11 stay clear.
- R9: Arbitration loss reported with `be_done` sets bit 6 and returns to idle at once, with no STOP.
- R10: An invalid command sets bit 8 and issues no bus action. A command is invalid if its mode code is above 2, or if the count its direction needs is zero. In mode 2 it is also invalid if the transmit count is zero or above the transmit FIFO depth, if the receive count is zero, or if header 1 bit 0 is set.
- R11: Status bit 12 is 1 while busy, the transmit FIFO is not full, and the transmit bytes still to send exceed its fill level. Status bit 13 is 1 while the receive FIFO is not empty.
- R12: After reset the status word, `cmd_status` and `be_req` are zero. Writing 1 to a `sts_clr` bit clears that sticky status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_wdata | input | 4 | Command: bit 3 start, bits 2:0 mode |
| cmd_status | output | 4 | Bit 3 busy, bits 2:0 mode of current or last command |
| hdr1 | input | 8 | First header byte, bit 0 read/not-write |
| hdr2 | input | 8 | Second header byte for 10-bit addresses |
| tx_count | input | 8 | Bytes to transmit |
| rx_count | input | 8 | Bytes to receive, read live |
| txf_push | input | 1 | Transmit FIFO push |
| txf_wdata | input | 8 | Transmit FIFO data |
| txf_level | output | 4 | Transmit FIFO fill level |
| rxf_pop | input | 1 | Receive FIFO pop |
| rxf_rdata | output | 8 | Receive FIFO head |
| rxf_level | output | 4 | Receive FIFO fill level |
| sts_clr | input | 14 | Write-one-to-clear for sticky status bits |
| status | output | 14 | Status word |
| be_req | output | 1 | Bus action request |
| be_op | output | 2 | Bus action code |
| be_wdata | output | 8 | Byte to write |
| be_last | output | 1 | Read byte is the last (master NAKs it) |
| be_done | input | 1 | Bus action complete |
| be_rdata | input | 8 | Byte read, valid with done |
| be_nak | input | 1 | Written byte was not acknowledged, valid with done |
| be_arb_lost | input | 1 | Arbitration lost, valid with done |

## Verification
Several properties hold on every cycle, and the assertions check them there. A pending bus action stays put until done. A NAK on a write is followed directly by a STOP request. Arbitration loss drops busy on the next cycle. The held mode never requests a STOP unless an error occurred. The done and invalid-parameter bits only ever rise while idle. The FIFOs never overflow or underflow.

The bench scenarios are needed for the rest:
- the exact ordering of headers, repeated start and data for each mode;
- the 10-bit second header;
- the flagging of the last read byte under a live count rewrite;
- the receive data order;
- the service-flag driven refill of a transfer longer than the transmit FIFO;
- the ignoring of commands while busy.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
    localparam int TXF_DEPTH = 8;
    localparam int RXF_DEPTH = 8;
    localparam int CNT_W     = 8;
    localparam int ST_W      = 14;
    localparam int CMD_GO    = 3;

    localparam logic [2:0] MD_HOLD = 3'd0;
    localparam logic [2:0] MD_AUTO = 3'd1;
    localparam logic [2:0] MD_SEQ  = 3'd2;

    localparam logic [1:0] OP_START = 2'd0;
    localparam logic [1:0] OP_STOP  = 2'd1;
    localparam logic [1:0] OP_WRITE = 2'd2;
    localparam logic [1:0] OP_READ  = 2'd3;

    localparam int ST_RXSVC    = 13;
    localparam int ST_TXSVC    = 12;
    localparam int ST_HOLDDONE = 11;
    localparam int ST_AUTODONE = 10;
    localparam int ST_STOPDONE = 9;
    localparam int ST_BADPARM  = 8;
    localparam int ST_ARB      = 6;
    localparam int ST_DNAK     = 5;
    localparam int ST_ANAK     = 4;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADR1, S_ADR2, S_TX, S_RSTART, S_RADR, S_RX, S_STOP
    } seq_state_e;

    function automatic logic is_ten_hdr(input logic [7:0] b);
        return b[7:3] == 5'b11110;
    endfunction

    function automatic logic params_ok(input logic [2:0] mode, input logic rd,
                                       input int tx, input int rx, input int depth);
        case (mode)
            MD_HOLD, MD_AUTO: return rd ? (rx != 0) : (tx != 0);
            MD_SEQ:           return !rd && tx != 0 && tx <= depth && rx != 0;
            default:          return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/i2cseq_fifo.sv
module i2cseq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] cnt;
    logic             do_push, do_pop;

    assign full    = cnt == LVL_W'(DEPTH);
    assign empty   = cnt == '0;
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];
    assign level   = cnt;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end

    a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst) push |-> !full);
    a_r11_no_underflow: assert property (@(posedge clk) disable iff (rst) pop |-> !empty);
endmodule

// File: rtl/i2cseq_ctrl.sv
module i2cseq_ctrl
    import i2cseq_pkg::*;
#(
    parameter int TXD = TXF_DEPTH,
    parameter int CW  = CNT_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_wr,
    input  logic [3:0]      cmd_wdata,
    input  logic [7:0]      hdr1,
    input  logic [7:0]      hdr2,
    input  logic [CW-1:0]   tx_count,
    input  logic [CW-1:0]   rx_count,
    input  logic            txf_empty,
    input  logic [7:0]      txf_head,
    input  logic            rxf_full,
    input  logic [ST_W-1:0] sts_clr,
    input  logic            be_done,
    input  logic            be_nak,
    input  logic            be_arb_lost,
    output logic            busy,
    output logic [2:0]      mode,
    output logic [CW-1:0]   tx_left,
    output logic [ST_W-1:0] flags,
    output logic            txf_pop,
    output logic            rxf_push,
    output logic            be_req,
    output logic [1:0]      be_op,
    output logic [7:0]      be_wdata,
    output logic            be_last
);
    seq_state_e      state, state_d;
    logic [2:0]      mode_d;
    logic            rd_q, rd_d, ten_q, ten_d, err_q, err_d, hs;
    logic [CW-1:0]   tx_left_d, rx_got, rx_got_d;
    logic [ST_W-1:0] set;

    // bus action request
    always_comb begin
        be_req   = 1'b0;
        be_op    = OP_START;
        be_wdata = '0;
        be_last  = 1'b0;
        case (state)
            S_START, S_RSTART: be_req = 1'b1;
            S_ADR1:   begin be_req = 1'b1; be_op = OP_WRITE; be_wdata = hdr1; end
            S_ADR2:   begin be_req = 1'b1; be_op = OP_WRITE; be_wdata = hdr2; end
            S_TX:     begin be_req = tx_left != '0 && !txf_empty; be_op = OP_WRITE; be_wdata = txf_head; end
            S_RADR:   begin be_req = 1'b1; be_op = OP_WRITE; be_wdata = {hdr1[7:1], 1'b1}; end
            S_RX: begin
                be_req  = rx_got < rx_count && !rxf_full;
                be_op   = OP_READ;
                be_last = ({1'b0, rx_got} + 1'b1) == {1'b0, rx_count};
            end
            S_STOP:   begin be_req = 1'b1; be_op = OP_STOP; end
            default: ;
        endcase
    end

    assign hs = be_req && be_done;

    // next state and status events
    always_comb begin
        state_d   = state;
        mode_d    = mode;
        rd_d      = rd_q;
        ten_d     = ten_q;
        err_d     = err_q;
        tx_left_d = tx_left;
        rx_got_d  = rx_got;
        set       = '0;
        txf_pop   = 1'b0;
        rxf_push  = 1'b0;
        if (state == S_IDLE) begin
            if (cmd_wr && cmd_wdata[CMD_GO]) begin
                if (params_ok(cmd_wdata[2:0], hdr1[0], int'(tx_count), int'(rx_count), TXD)) begin
                    state_d   = S_START;
                    mode_d    = cmd_wdata[2:0];
                    rd_d      = hdr1[0];
                    ten_d     = is_ten_hdr(hdr1);
                    err_d     = 1'b0;
                    tx_left_d = tx_count;
                    rx_got_d  = '0;
                end else begin
                    set[ST_BADPARM] = 1'b1;
                end
            end
        end else if (hs && be_arb_lost) begin
            set[ST_ARB] = 1'b1;
            state_d     = S_IDLE;
        end else begin
            case (state)
                S_START:  if (hs) state_d = S_ADR1;
                S_RSTART: if (hs) state_d = S_RADR;
                S_ADR1, S_ADR2, S_RADR: if (hs) begin
                    if (be_nak) begin
                        set[ST_ANAK] = 1'b1;
                        err_d        = 1'b1;
                        state_d      = S_STOP;
                    end else if (state == S_ADR1 && ten_q) state_d = S_ADR2;
                    else if (state == S_RADR || rd_q)      state_d = S_RX;
                    else                                   state_d = S_TX;
                end
                S_TX: begin
                    if (tx_left == '0) begin
                        if (mode == MD_SEQ) state_d = S_RSTART;
                        else if (mode == MD_HOLD) begin set[ST_HOLDDONE] = 1'b1; state_d = S_IDLE; end
                        else state_d = S_STOP;
                    end else if (hs) begin
                        txf_pop   = 1'b1;
                        tx_left_d = tx_left - 1'b1;
                        if (be_nak) begin
                            set[ST_DNAK] = 1'b1;
                            err_d        = 1'b1;
                            state_d      = S_STOP;
                        end
                    end
                end
                S_RX: begin
                    if (rx_got >= rx_count) begin
                        if (mode == MD_HOLD) begin set[ST_HOLDDONE] = 1'b1; state_d = S_IDLE; end
                        else state_d = S_STOP;
                    end else if (hs) begin
                        rxf_push = 1'b1;
                        rx_got_d = rx_got + 1'b1;
                    end
                end
                S_STOP: if (hs) begin
                    if (!err_q) begin
                        set[ST_STOPDONE] = 1'b1;
                        set[ST_AUTODONE] = 1'b1;
                    end
                    state_d = S_IDLE;
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= S_IDLE;
            mode    <= MD_HOLD;
            rd_q    <= 1'b0;
            ten_q   <= 1'b0;
            err_q   <= 1'b0;
            tx_left <= '0;
            rx_got  <= '0;
            flags   <= '0;
        end else begin
            state   <= state_d;
            mode    <= mode_d;
            rd_q    <= rd_d;
            ten_q   <= ten_d;
            err_q   <= err_d;
            tx_left <= tx_left_d;
            rx_got  <= rx_got_d;
            flags   <= (flags & ~sts_clr) | set;
        end
    end

    assign busy = state != S_IDLE;

    a_r2_req_held: assert property (@(posedge clk) disable iff (rst)
        be_req && !be_done && be_op != OP_READ |=> be_req && $stable(be_op) && $stable(be_wdata));
    a_r9_arb_to_idle: assert property (@(posedge clk) disable iff (rst)
        be_req && be_done && be_arb_lost |=> !busy);
    a_r8_nak_then_stop: assert property (@(posedge clk) disable iff (rst)
        be_req && be_done && be_nak && !be_arb_lost && be_op == OP_WRITE |=> be_req && be_op == OP_STOP);
    a_r4_hold_no_stop: assert property (@(posedge clk) disable iff (rst)
        busy && mode == MD_HOLD && !err_q |-> !(be_req && be_op == OP_STOP));
    a_r10_bad_while_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[ST_BADPARM]) |-> !busy);
    a_r3_done_while_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[ST_AUTODONE]) |-> !busy);
endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int TXD = TXF_DEPTH,
    parameter int RXD = RXF_DEPTH,
    parameter int CW  = CNT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_wr,
    input  logic [3:0]                 cmd_wdata,
    output logic [3:0]                 cmd_status,
    input  logic [7:0]                 hdr1,
    input  logic [7:0]                 hdr2,
    input  logic [CW-1:0]              tx_count,
    input  logic [CW-1:0]              rx_count,
    input  logic                       txf_push,
    input  logic [7:0]                 txf_wdata,
    output logic [$clog2(TXD+1)-1:0]   txf_level,
    input  logic                       rxf_pop,
    output logic [7:0]                 rxf_rdata,
    output logic [$clog2(RXD+1)-1:0]   rxf_level,
    input  logic [ST_W-1:0]            sts_clr,
    output logic [ST_W-1:0]            status,
    output logic                       be_req,
    output logic [1:0]                 be_op,
    output logic [7:0]                 be_wdata,
    output logic                       be_last,
    input  logic                       be_done,
    input  logic [7:0]                 be_rdata,
    input  logic                       be_nak,
    input  logic                       be_arb_lost
);
    logic            txf_full, txf_empty, txf_pop, rxf_full, rxf_empty, rxf_push, busy;
    logic [7:0]      txf_head;
    logic [2:0]      mode;
    logic [CW-1:0]   tx_left;
    logic [ST_W-1:0] flags;

    i2cseq_fifo #(.W(8), .DEPTH(TXD)) u_txf (
        .clk(clk), .rst(rst), .push(txf_push), .wdata(txf_wdata), .pop(txf_pop),
        .rdata(txf_head), .level(txf_level), .full(txf_full), .empty(txf_empty));

    i2cseq_fifo #(.W(8), .DEPTH(RXD)) u_rxf (
        .clk(clk), .rst(rst), .push(rxf_push), .wdata(be_rdata), .pop(rxf_pop),
        .rdata(rxf_rdata), .level(rxf_level), .full(rxf_full), .empty(rxf_empty));

    i2cseq_ctrl #(.TXD(TXD), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
        .hdr1(hdr1), .hdr2(hdr2), .tx_count(tx_count), .rx_count(rx_count),
        .txf_empty(txf_empty), .txf_head(txf_head), .rxf_full(rxf_full),
        .sts_clr(sts_clr), .be_done(be_done), .be_nak(be_nak), .be_arb_lost(be_arb_lost),
        .busy(busy), .mode(mode), .tx_left(tx_left), .flags(flags),
        .txf_pop(txf_pop), .rxf_push(rxf_push), .be_req(be_req), .be_op(be_op),
        .be_wdata(be_wdata), .be_last(be_last));

    assign cmd_status = {busy, mode};

    always_comb begin
        status           = flags;
        status[ST_RXSVC] = !rxf_empty;
        status[ST_TXSVC] = busy && !txf_full && (int'(tx_left) > int'(txf_level));
    end
endmodule

// File: tb/i2cseq_top_bench.sv
module i2cseq_top_bench;
    import i2cseq_pkg::*;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0, rst = 1'b1;
    logic cmd_wr = 0, txf_push = 0, rxf_pop = 0, be_done = 0, be_nak = 0, be_arb_lost = 0;
    logic [3:0] cmd_wdata = 0, cmd_status, txf_level, rxf_level;
    logic [7:0] hdr1 = 0, hdr2 = 0, tx_count = 0, rx_count = 0, txf_wdata = 0, rxf_rdata, be_wdata, be_rdata = 0;
    logic [13:0] sts_clr = 0, status;
    logic be_req, be_last;
    logic [1:0] be_op;

    i2cseq_top u_i2cseq_top (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    int expq[$];
    int opn = 0, nak_at = -1, arb_at = -1, lat = 0, code = 0;
    int refill_left = 0, refill_val = 0;
    bit rewrite_en = 0, saw_svc = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int enc(input logic [1:0] op, input logic [7:0] d, input logic l);
        return int'(op) * 512 + int'(d) * 2 + int'(l);
    endfunction

    // reference bus engine: each completed action is compared with the expected list
    always @(negedge clk) begin
        if (rst || be_done) begin
            be_done = 0; be_nak = 0; be_arb_lost = 0; lat = 0;
        end else if (be_req) begin
            if (lat == 1) begin
                lat = 0;
                code = enc(be_op, (be_op == OP_WRITE) ? be_wdata : 8'h00,
                           (be_op == OP_READ) ? be_last : 1'b0);
                if (opn < expq.size()) check(code == expq[opn], "R2 action order", code, expq[opn]);
                else check(1'b0, "R2 unexpected action", code, -1);
                be_rdata    = 8'hC0 + 8'(opn);
                be_nak      = (opn == nak_at);
                be_arb_lost = (opn == arb_at);
                be_done     = 1;
                opn++;
            end else lat++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic new_case();
        expq.delete(); opn = 0; nak_at = -1; arb_at = -1;
    endtask
    task automatic ex(input logic [1:0] op, input logic [7:0] d, input logic l);
        expq.push_back(enc(op, d, l));
    endtask
    task automatic push_tx(input logic [7:0] d);
        @(negedge clk); txf_push = 1; txf_wdata = d;
        @(negedge clk); txf_push = 0;
    endtask
    task automatic pop_rx(input logic [7:0] exp, input string req);
        @(negedge clk); check(rxf_rdata == exp, req, rxf_rdata, exp); rxf_pop = 1;
        @(negedge clk); rxf_pop = 0;
    endtask
    task automatic clear_sts();
        @(negedge clk); sts_clr = '1;
        @(negedge clk); sts_clr = '0;
    endtask

    task automatic run(input logic [2:0] md, input bit poke, input string req);
        int n = 0;
        @(negedge clk); cmd_wr = 1; cmd_wdata = {1'b1, md};
        @(negedge clk); cmd_wr = 0;
        saw_svc = 0;
        while (cmd_status[3]) begin
            txf_push = 0; cmd_wr = 0;
            if (status[ST_TXSVC]) saw_svc = 1;
            if (refill_left > 0 && status[ST_TXSVC]) begin
                txf_push = 1; txf_wdata = 8'(refill_val); refill_val++; refill_left--;
            end
            if (rewrite_en && rxf_level != 0) begin rx_count = 4; rewrite_en = 0; end
            if (poke && n == 2) begin cmd_wr = 1; cmd_wdata = {1'b1, MD_SEQ}; end
            if (poke && n == 4) check(cmd_status[2:0] == md, "R1 mode kept while busy", cmd_status[2:0], md);
            @(negedge clk);
            n++;
            if (n > 5000) begin check(1'b0, "R1 transfer never ended", n, 5000); break; end
        end
        txf_push = 0; cmd_wr = 0;
        check(opn == expq.size(), req, opn, expq.size());
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(status == 0, "R12 reset status", status, 0);
        check(cmd_status == 0, "R12 reset cmd_status", cmd_status, 0);
        check(be_req == 0, "R12 reset request", be_req, 0);

        // R3 + R1: stop-terminated write, command poked while busy
        new_case(); hdr1 = 8'hA4; tx_count = 3;
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA4, 0); ex(OP_WRITE, 8'h11, 0);
        ex(OP_WRITE, 8'h22, 0); ex(OP_WRITE, 8'h33, 0); ex(OP_STOP, 0, 0);
        run(MD_AUTO, 1, "R3 action count, R1 ignored command");
        check(status[ST_AUTODONE] && status[ST_STOPDONE] && !status[ST_HOLDDONE], "R3 done bits", status, 14'h0600);
        clear_sts();
        check(status == 0, "R12 sticky clear", status, 0);

        // R4: held 10-bit write, no STOP
        new_case(); hdr1 = 8'hF6; hdr2 = 8'h5A; tx_count = 2;
        push_tx(8'h81); push_tx(8'h82);
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hF6, 0); ex(OP_WRITE, 8'h5A, 0);
        ex(OP_WRITE, 8'h81, 0); ex(OP_WRITE, 8'h82, 0);
        run(MD_HOLD, 0, "R4 action count");
        check(status == 14'h0800, "R4 only held-done bit", status, 14'h0800);
        clear_sts();

        // R6 + R11: stop-terminated read of 3 bytes
        new_case(); hdr1 = 8'hA5; rx_count = 3;
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA5, 0); ex(OP_READ, 0, 0);
        ex(OP_READ, 0, 0); ex(OP_READ, 0, 1); ex(OP_STOP, 0, 0);
        run(MD_AUTO, 0, "R6 action count");
        check(status[ST_RXSVC] == 1, "R11 rx service set", status[ST_RXSVC], 1);
        pop_rx(8'hC2, "R6 rx byte 0"); pop_rx(8'hC3, "R6 rx byte 1"); pop_rx(8'hC4, "R6 rx byte 2");
        @(negedge clk);
        check(status[ST_RXSVC] == 0, "R11 rx service clear", status[ST_RXSVC], 0);
        clear_sts();

        // R5: combined write then read
        new_case(); hdr1 = 8'hA4; tx_count = 2; rx_count = 2;
        push_tx(8'h44); push_tx(8'h55);
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA4, 0); ex(OP_WRITE, 8'h44, 0); ex(OP_WRITE, 8'h55, 0);
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA5, 0); ex(OP_READ, 0, 0); ex(OP_READ, 0, 1); ex(OP_STOP, 0, 0);
        run(MD_SEQ, 0, "R5 action count");
        check(status[ST_AUTODONE] && status[ST_STOPDONE], "R5 done bits", status, 14'h0600);
        pop_rx(8'hC6, "R5 rx byte 0"); pop_rx(8'hC7, "R5 rx byte 1");
        clear_sts();

        // R8: header NAK on a read
        new_case(); hdr1 = 8'hA5; rx_count = 2; nak_at = 1;
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA5, 0); ex(OP_STOP, 0, 0);
        run(MD_AUTO, 0, "R8 header NAK actions");
        check(status == 14'h0010, "R8 header NAK status", status, 14'h0010);
        clear_sts();

        // R8: data NAK on final byte
        new_case(); hdr1 = 8'hA4; tx_count = 2; nak_at = 3;
        push_tx(8'h71); push_tx(8'h72);
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA4, 0); ex(OP_WRITE, 8'h71, 0); ex(OP_WRITE, 8'h72, 0); ex(OP_STOP, 0, 0);
        run(MD_AUTO, 0, "R8 data NAK actions");
        check(status == 14'h0020, "R8 data NAK status", status, 14'h0020);
        clear_sts();

        // R9: arbitration loss on header
        new_case(); hdr1 = 8'hA5; rx_count = 1; arb_at = 1;
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA5, 0);
        run(MD_AUTO, 0, "R9 no STOP after loss");
        check(status == 14'h0040, "R9 arbitration status", status, 14'h0040);
        clear_sts();

        // R10: invalid commands
        new_case(); hdr1 = 8'hA4; tx_count = 9; rx_count = 1;
        run(MD_SEQ, 0, "R10 oversize combined issues nothing");
        check(status == 14'h0100, "R10 oversize flag", status, 14'h0100);
        clear_sts();
        new_case(); tx_count = 0;
        run(MD_AUTO, 0, "R10 zero count issues nothing");
        check(status == 14'h0100, "R10 zero count flag", status, 14'h0100);
        clear_sts();
        new_case(); tx_count = 1;
        run(3'd3, 0, "R10 bad mode issues nothing");
        check(status == 14'h0100 && cmd_status[3] == 0, "R10 bad mode flag", status, 14'h0100);
        clear_sts();

        // R7: live rewrite of the receive count
        new_case(); hdr1 = 8'hA5; rx_count = 2; rewrite_en = 1;
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA5, 0); ex(OP_READ, 0, 0); ex(OP_READ, 0, 0);
        ex(OP_READ, 0, 0); ex(OP_READ, 0, 1); ex(OP_STOP, 0, 0);
        run(MD_AUTO, 0, "R7 extended read count");
        for (int i = 0; i < 4; i++) pop_rx(8'hC2 + 8'(i), "R7 rx byte");
        clear_sts();

        // R11: transfer longer than the transmit FIFO, refilled on the service flag
        new_case(); hdr1 = 8'hA4; tx_count = 10;
        for (int i = 0; i < 8; i++) push_tx(8'h10 + 8'(i));
        refill_left = 2; refill_val = 8'h18;
        ex(OP_START, 0, 0); ex(OP_WRITE, 8'hA4, 0);
        for (int i = 0; i < 10; i++) ex(OP_WRITE, 8'h10 + 8'(i), 0);
        ex(OP_STOP, 0, 0);
        run(MD_AUTO, 0, "R11 refilled write actions");
        check(saw_svc == 1, "R11 tx service seen", saw_svc, 1);
        check(refill_left == 0 && status[ST_TXSVC] == 0, "R11 tx service idle", status[ST_TXSVC], 0);
        check(txf_level == 0, "R11 tx FIFO drained", txf_level, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule